// File: doc/BRIEF.md
# Store-multiple register sequencer

This unit carries out a single store-multiple instruction over several cycles. A one-cycle `start` pulse presents a 32-bit instruction word, the base register value and a configuration bit that can forbid the instruction. If the word carries the right opcode and fixed bits, the unit latches the first register number, the word count and the start address. It then works through the steps in order. For each step it reads one register through a read port with one cycle of latency and presents that value as one full-word write on a valid/ready memory port.

The register number rises by one per step. After register 31 it continues at register 16. A first register of 0 stores register 0 on every step. A count field of zero stands for eight words. The byte offset is a 9-bit signed immediate whose sign bit lies apart from its low eight bits. An `abort` input ends the sequence at any point. Writes that were already accepted stay committed, and the unit returns to idle so that the same instruction can be issued again from its first step.

Top module: `stmul_seq`

## Requirements
- R1: The unit accepts a `start` only when bits 31:26 are 101001, bits 11 and 10 are both 1, and bits 9:8 are 00. Any other word causes no write, no `done` and no `ri_exc`.
- R2: The first write goes to `base` plus the sign extension of the 9-bit offset {bit 15, bits 7:0}.
- R3: The 3-bit count field in bits 14:12 gives the number of writes. The value 0 means eight writes.
- R4: With the first register r (bits 25:21) nonzero, step i reads register r+i when that is below 32, and r+i-16 otherwise.
- R5: With r equal to 0, every step reads register 0.
- R6: Each write's address is 4 more than the previous one, modulo 2^32.
- R7: A matching `start` with `cfg_block` high raises `ri_exc` for exactly the next cycle and starts no write.
- R8: While `mem_valid` is high and `mem_ready` is low, the address and data hold their values and `mem_valid` stays high.
- R9: `done` is high for exactly the one cycle after the last write is accepted.
- R10: A `start` that arrives while a sequence is running has no effect on that sequence.
- R11: `abort` returns the unit to idle with no further write and no `done`. A later `start` repeats the instruction from its first step.
- R12: After reset, `mem_valid`, `done` and `ri_exc` are low.
- R13: Each write's data is the value the register read port returned one cycle after that step's index was driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issue the instruction on `instr` |
| instr | input | 32 | Instruction word |
| base | input | 32 | Base register value |
| cfg_block | input | 1 | Instruction forbidden; raise a reserved-instruction exception |
| abort | input | 1 | Fault or interrupt: drop the rest of the sequence |
| rf_idx | output | 5 | Register-file read index |
| rf_data | input | 32 | Register-file read data, one cycle after the index |
| mem_addr | output | 32 | Write byte address |
| mem_wdata | output | 32 | Write data |
| mem_valid | output | 1 | Write request |
| mem_ready | input | 1 | Memory accepts the write |
| done | output | 1 | Sequence complete pulse |
| ri_exc | output | 1 | Reserved-instruction exception pulse |

## Verification
A wrong step counter or a wrong first-register latch shows up at the first write after the error, either as a register value from the wrong index or as a write count that differs from the field. Both are caught within about three cycles of the step going wrong. A bad address register is exposed on the same write as an address that no longer rises by exactly four. The bench sweeps every first register with every count field, under a stalling ready pattern, and compares each write against arithmetic done in the bench. A lost handshake hold or a late `done` is visible on the very next cycle.

// File: rtl/stmul_pkg.sv
package stmul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_CAP  = 2'd2,
        ST_WR   = 2'd3
    } stm_state_e;

    localparam logic [5:0] STM_OPCODE = 6'b101001;
    localparam int         STM_REG_W  = 5;
    localparam int         STM_CNT_W  = 3;
endpackage

// File: rtl/stmul_decode.sv
module stmul_decode #(
    parameter int ADDR_W = 32,
    parameter int REG_W  = 5,
    parameter int CNT_W  = 3
) (
    input  logic [31:0]       instr,
    output logic              match,
    output logic [REG_W-1:0]  rt,
    output logic [ADDR_W-1:0] offs,
    output logic [CNT_W:0]    nwords
);
    import stmul_pkg::*;

    localparam int IMM_W = 9;

    logic [IMM_W-1:0] imm;
    logic [CNT_W-1:0] cfield;
    logic             unused_rs;

    // base register number is supplied by the caller as a value
    assign unused_rs = ^instr[20:16];

    assign match  = (instr[31:26] == STM_OPCODE) && instr[11] && instr[10]
                    && (instr[9:8] == 2'b00);
    assign rt     = instr[25:21];
    assign imm    = {instr[15], instr[7:0]};
    assign offs   = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
    assign cfield = instr[14:12];
    assign nwords = (cfield == '0) ? (CNT_W+1)'(1 << CNT_W) : {1'b0, cfield};
endmodule

// File: rtl/stmul_regidx.sv
module stmul_regidx #(
    parameter int REG_W   = 5,
    parameter int CNT_W   = 3,
    parameter int WRAP_TO = 16
) (
    input  logic [REG_W-1:0] rt,
    input  logic [CNT_W-1:0] step,
    output logic [REG_W-1:0] idx
);
    localparam int NREG = 1 << REG_W;

    logic [REG_W:0] sum;
    logic [REG_W:0] wrapped;

    assign sum     = {1'b0, rt} + (REG_W+1)'(step);
    assign wrapped = sum - (REG_W+1)'(NREG - WRAP_TO);

    always_comb begin
        if (rt == '0)
            idx = '0;
        else if (sum < (REG_W+1)'(NREG))
            idx = sum[REG_W-1:0];
        else
            idx = wrapped[REG_W-1:0];
    end
endmodule

// File: rtl/stmul_seq.sv
module stmul_seq #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int WRAP_TO    = 16,
    parameter int STEP_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       instr,
    input  logic [ADDR_W-1:0] base,
    input  logic              cfg_block,
    input  logic              abort,
    output logic [4:0]        rf_idx,
    input  logic [DATA_W-1:0] rf_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              done,
    output logic              ri_exc
);
    import stmul_pkg::*;

    localparam int REG_W = STM_REG_W;
    localparam int CNT_W = STM_CNT_W;

    typedef struct packed {
        stm_state_e        st;
        logic [REG_W-1:0]  rt;
        logic [CNT_W:0]    nwords;
        logic [CNT_W-1:0]  step;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              done;
        logic              ri;
    } seq_t;

    seq_t r_q, r_d;

    logic              dec_match;
    logic [REG_W-1:0]  dec_rt;
    logic [ADDR_W-1:0] dec_offs;
    logic [CNT_W:0]    dec_nwords;
    logic              last_step;

    stmul_decode #(.ADDR_W(ADDR_W), .REG_W(REG_W), .CNT_W(CNT_W)) u_dec (
        .instr  (instr),
        .match  (dec_match),
        .rt     (dec_rt),
        .offs   (dec_offs),
        .nwords (dec_nwords)
    );

    stmul_regidx #(.REG_W(REG_W), .CNT_W(CNT_W), .WRAP_TO(WRAP_TO)) u_idx (
        .rt   (r_q.rt),
        .step (r_q.step),
        .idx  (rf_idx)
    );

    assign last_step = ({1'b0, r_q.step} == (r_q.nwords - (CNT_W+1)'(1)));

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.ri   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start && dec_match) begin
                    if (cfg_block) begin
                        r_d.ri = 1'b1;
                    end else begin
                        r_d.st     = ST_RD;
                        r_d.rt     = dec_rt;
                        r_d.nwords = dec_nwords;
                        r_d.step   = '0;
                        r_d.addr   = base + dec_offs;
                    end
                end
            end
            ST_RD:  r_d.st = ST_CAP;
            ST_CAP: begin
                r_d.data = rf_data;
                r_d.st   = ST_WR;
            end
            ST_WR: begin
                if (mem_ready) begin
                    if (last_step) begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.step = r_q.step + CNT_W'(1);
                        r_d.addr = r_q.addr + ADDR_W'(STEP_BYTES);
                        r_d.st   = ST_RD;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (abort && (r_q.st != ST_IDLE)) begin
            r_d.st   = ST_IDLE;
            r_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_valid = (r_q.st == ST_WR);
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.data;
    assign done      = r_q.done;
    assign ri_exc    = r_q.ri;

    p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready && !abort |=>
            mem_valid && $stable(mem_addr) && $stable(mem_wdata));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ri_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ri_exc |-> !mem_valid && !done);

    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RD) && $past(r_q.st == ST_WR) |->
            mem_addr == $past(mem_addr) + ADDR_W'(STEP_BYTES));

    p_zero_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) && (r_q.rt == '0) |-> rf_idx == '0);

    p_wrap_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) && (r_q.rt != '0) |->
            (rf_idx >= r_q.rt) || (rf_idx >= 5'(WRAP_TO)));

    p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !mem_valid && !done);
endmodule

// File: tb/test_stmul_seq.sv
`timescale 1ns/1ps
module test_stmul_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] base = '0;
    logic        cfg_block = 1'b0;
    logic        abort = 1'b0;
    logic [4:0]  rf_idx;
    logic [31:0] rf_data = '0;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic        done;
    logic        ri_exc;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    stmul_seq i_stmul_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .base(base),
        .cfg_block(cfg_block), .abort(abort), .rf_idx(rf_idx), .rf_data(rf_data),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .done(done), .ri_exc(ri_exc)
    );

    function automatic logic [31:0] regval(input logic [4:0] i);
        return 32'hC000_0000 | ({27'd0, i} << 16) | ((32'(i) * 977 + 5) & 32'hFFFF);
    endfunction

    // register-file model: data one cycle after the index
    always_ff @(posedge clk) rf_data <= regval(rf_idx);

    function automatic logic [31:0] mk(input logic [4:0] rt, input logic [2:0] c3,
                                       input logic [8:0] s);
        return {6'b101001, rt, 5'd7, s[8], c3, 1'b1, 1'b1, 2'b00, s[7:0]};
    endfunction

    function automatic logic [4:0] exp_idx(input logic [4:0] rt, input int i);
        int v;
        if (rt == 0) return 5'd0;
        v = int'(rt) + i;
        return (v < 32) ? 5'(v) : 5'(v - 16);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // mode 0 normal, 1 start while busy, 2 abort after two writes
    task automatic run(input logic [4:0] rt, input logic [2:0] c3, input logic [8:0] s,
                       input logic [31:0] b, input int mode);
        logic [31:0] wa [16];
        logic [31:0] wd [16];
        int nacc = 0, last_acc = -1, done_cnt = 0, done_cyc = -1, abort_cyc = -1;
        int late_valid = 0, nw;
        bit stalled = 0, rdy;
        logic [31:0] pa = '0, pd = '0, offs;
        string rq;
        nw   = (c3 == 0) ? 8 : int'(c3);
        offs = {{23{s[8]}}, s};
        @(negedge clk);
        instr = mk(rt, c3, s); base = b; start = 1'b1;
        for (int cyc = 0; cyc < 150; cyc++) begin
            @(negedge clk);
            start = 1'b0; abort = 1'b0;
            if (mode == 1 && cyc == 1) begin
                instr = mk(rt ^ 5'd3, c3 + 3'd1, s ^ 9'h0F0); base = b ^ 32'h100; start = 1'b1;
            end
            if (stalled)
                chk(mem_valid && mem_addr == pa && mem_wdata == pd, "R8", "stall hold",
                    mem_addr, pa);
            rdy = ((cyc + int'(rt) + int'(c3)) % 3) != 2;
            if (mode == 2 && abort_cyc < 0 && mem_valid && nacc == 2) begin
                abort = 1'b1; rdy = 1'b0; abort_cyc = cyc;
            end else if (abort_cyc >= 0 && mem_valid) begin
                late_valid++;
            end
            mem_ready = rdy;
            if (mem_valid && rdy && abort_cyc < 0) begin
                if (nacc < 16) begin wa[nacc] = mem_addr; wd[nacc] = mem_wdata; end
                nacc++; last_acc = cyc;
            end
            stalled = mem_valid && !rdy && !abort;
            pa = mem_addr; pd = mem_wdata;
            if (done) begin done_cnt++; done_cyc = cyc; end
            if (ri_exc) chk(0, "R7", "unexpected exception", 32'd1, 32'd0);
            if (done_cyc >= 0 && cyc > done_cyc + 2) break;
            if (abort_cyc >= 0 && cyc > abort_cyc + 12) break;
        end
        mem_ready = 1'b0;
        rq = (mode == 1) ? "R10" : "R3";
        if (mode == 2) begin
            chk(nacc == 2, "R11", "writes before abort", 32'(nacc), 32'd2);
            chk(done_cnt == 0 && late_valid == 0, "R11", "activity after abort",
                32'(done_cnt + late_valid), 32'd0);
            return;
        end
        chk(nacc == nw, rq, "write count", 32'(nacc), 32'(nw));
        for (int i = 0; i < nw && i < nacc; i++) begin
            logic [31:0] ea, ed;
            ea = b + offs + 32'(4 * i);
            ed = regval(exp_idx(rt, i));
            chk(wa[i] == ea, (i == 0) ? "R2" : "R6", "address", wa[i], ea);
            chk(wd[i] == ed, (rt == 0) ? "R5" : "R4_R13", "data", wd[i], ed);
        end
        chk(done_cnt == 1 && done_cyc == last_acc + 1, "R9", "done timing",
            32'(done_cyc), 32'(last_acc + 1));
    endtask

    task automatic quiet(input logic [31:0] w, input bit blk, input string req);
        int act = 0, ri_seen = 0;
        @(negedge clk);
        instr = w; base = 32'h4000; cfg_block = blk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ri_seen = ri_exc;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (mem_valid || done || ri_exc) act++;
        end
        cfg_block = 1'b0;
        if (req == "R7")
            chk(ri_seen == 1, "R7", "exception pulse", 32'(ri_seen), 32'd1);
        else
            chk(ri_seen == 0, "R1", "exception on foreign word", 32'(ri_seen), 32'd0);
        chk(act == 0, req, "activity after start", 32'(act), 32'd0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!mem_valid && !done && !ri_exc, "R12", "reset outputs",
            {29'd0, mem_valid, done, ri_exc}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_valid && !done && !ri_exc, "R12", "idle after reset",
            {29'd0, mem_valid, done, ri_exc}, 32'd0);

        for (int rt = 0; rt < 32; rt++)
            for (int c3 = 0; c3 < 8; c3++)
                run(5'(rt), 3'(c3), 9'((rt * 37 + c3 * 59) % 512),
                    (rt % 2 == 1) ? 32'hFFFF_FFE0 + 32'(c3) : 32'h1000_0000 + 32'(rt * 256), 0);

        run(5'd31, 3'd3, 9'h1FF, 32'h0000_0000, 0);
        run(5'd17, 3'd0, 9'h100, 32'h0000_0080, 0);
        run(5'd0,  3'd5, 9'h0FF, 32'h7FFF_FFF0, 0);

        run(5'd20, 3'd4, 9'h010, 32'h2000_0000, 1);
        run(5'd29, 3'd0, 9'h1F0, 32'h3000_0000, 1);

        run(5'd30, 3'd5, 9'h024, 32'h5000_0000, 2);
        run(5'd30, 3'd5, 9'h024, 32'h5000_0000, 0);

        quiet(mk(5'd9, 3'd2, 9'h004) ^ 32'h0400_0000, 1'b0, "R1");
        quiet(mk(5'd9, 3'd2, 9'h004) & ~32'h0000_0800, 1'b0, "R1");
        quiet(mk(5'd9, 3'd2, 9'h004) & ~32'h0000_0400, 1'b0, "R1");
        quiet(mk(5'd9, 3'd2, 9'h004) | 32'h0000_0100, 1'b1, "R1");
        quiet(mk(5'd9, 3'd2, 9'h004), 1'b1, "R7");
        run(5'd9, 3'd2, 9'h004, 32'h4000, 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule